// File: doc/BRIEF.md
# GPIO Bank Controller with Pin Interrupts

This block controls a bank of general-purpose pins arranged as ports of eight pins each, four ports per bank by default. Every pin has a register bit for GPIO/alternate-function mode, a lock, an output enable and an output value. The block also keeps a synchronised copy of the pin level and a latched interrupt status, and each pin has its own enable, a three-bit trigger code and a clear control. A single-cycle register bus reaches every register. A second, masked address window lets software change chosen pins of a word without a read-modify-write.

The pad side is reduced to three vectors out (mode, output enable, output value) and one vector in. Incoming levels pass through a synchroniser. The block then compares each synchronised sample with the one before it, so it can detect level, single-edge and both-edge conditions. One interrupt line is the OR of every enabled, pending status bit.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: The word address is {masked, reg[2:0], port[1:0]}. The reg codes are 0 config, 1 output enable, 2 output value, 3 input, 4 status, 5 interrupt enable, 6 trigger, 7 clear. A read with bus_en high returns the addressed register in the same cycle, with unused bits zero. A read with bus_en low returns zero. Masked addresses read the same data as their plain twins.
- R2: Config bit n (n in 0..7) sets the mode of pin n of that port, where 1 is GPIO, and drives pin_gpio_mode. Config bit n+8 is the pin's lock bit.
- R3: A plain config write ORs data bits [15:8] into the lock bits. No write clears a lock bit, and only reset does. Writes to the mode, output-enable and output-value bits of a locked pin are ignored.
- R4: The output-enable and output-value registers drive pin_oe and pin_out from the clock edge that commits the write.
- R5: The input register is read-only. It shows each pin_in level two clocks later, whatever the output enable is.
- R6: Trigger word bits are: n for polarity (1 = high/rising), n+8 for edge (1) or level (0), and n+16 for any-change. A level-triggered pin sets its status on every cycle that its sampled level equals the polarity.
- R7: An edge-triggered pin sets its status when its new sample differs from the previous one in the direction given by the polarity.
- R8: An any-change pin sets its status on both rising and falling sample changes, whatever its polarity and edge bits are.
- R9: Writing 1 to clear bit n drops status bit n, and writing 0 does nothing. If a status set and a clear fall on the same cycle, the set wins. Writes to the status register are ignored, and the clear register reads as zero.
- R10: irq is high exactly when some status bit and its enable bit are both 1. Status bits latch even when their enable bit is 0.
- R11: A write to a masked address (address bit 5 set) updates only the bits of data [7:0] whose enable bit in data [15:8] is 1. The lock still applies. Lock bits and the upper trigger fields are left alone.
- R12: Reset clears every register, so pin_gpio_mode, pin_oe, pin_out and irq are all zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_en | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word address {masked, reg, port} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Output value per pin |
| pin_oe | output | 32 | Output enable per pin |
| pin_gpio_mode | output | 32 | 1 = GPIO, 0 = alternate function |
| irq | output | 1 | Combined interrupt |

## Verification
The checker asserts on every cycle that lock bits never fall, and that a locked pin's mode, output enable and output value never move. It also checks that masked writes leave locks alone, that a status bit only falls where a clear was written, that irq stays low while no enable bit is set, and that one write reaches at most one port. The bench's scenarios show the rest: the two-clock input delay, the way each trigger code responds to rising and falling pin changes, a set winning over a clear in the same cycle, and merged masked writes. A behavioural model compares the read path, outputs and irq against the design on every clock.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam int LANE_W    = 8;
   localparam int REG_SEL_W = 3;

   typedef enum logic [REG_SEL_W-1:0] {
      RG_CFG  = 3'd0,
      RG_OE   = 3'd1,
      RG_OUT  = 3'd2,
      RG_IN   = 3'd3,
      RG_STAT = 3'd4,
      RG_IEN  = 3'd5,
      RG_TRIG = 3'd6,
      RG_CLR  = 3'd7
   } gpio_reg_e;

   // one decoded bus write, split into byte lanes
   typedef struct packed {
      logic              en;
      logic              masked;
      gpio_reg_e         sel;
      logic [LANE_W-1:0] lo;
      logic [LANE_W-1:0] mid;
      logic [LANE_W-1:0] hi;
   } gpio_wr_t;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] din,
   output logic [W-1:0] cur,
   output logic [W-1:0] prev
);

   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) stg[s] <= '0;
            else     stg[s] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) stg[s] <= '0;
            else     stg[s] <= stg[s-1];
         end
      end
   end

   // history register used by the edge detectors
   always_ff @(posedge clk) begin
      if (rst) prev <= '0;
      else     prev <= stg[STAGES-1];
   end

   assign cur = stg[STAGES-1];

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
   import gpio_bank_pkg::*;
#(
   parameter int PINS = 8
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            we,
   input  gpio_wr_t        wr,
   output logic [PINS-1:0] mode,
   output logic [PINS-1:0] lock,
   output logic [PINS-1:0] oe,
   output logic [PINS-1:0] out,
   output logic [PINS-1:0] ien,
   output logic [PINS-1:0] pol,
   output logic [PINS-1:0] edg,
   output logic [PINS-1:0] anyc,
   output logic [PINS-1:0] clr
);

   logic [PINS-1:0] wval;
   logic [PINS-1:0] wmask;
   logic [PINS-1:0] upd;

   assign wval  = wr.lo[PINS-1:0];
   assign wmask = wr.masked ? wr.mid[PINS-1:0] : '1;
   assign upd   = wmask & ~lock;

   function automatic logic [PINS-1:0] merge(input logic [PINS-1:0] old_v,
                                             input logic [PINS-1:0] new_v,
                                             input logic [PINS-1:0] en_v);
      return (old_v & ~en_v) | (new_v & en_v);
   endfunction

   always_ff @(posedge clk) begin
      if (rst) begin
         mode <= '0;
         lock <= '0;
         oe   <= '0;
         out  <= '0;
         ien  <= '0;
         pol  <= '0;
         edg  <= '0;
         anyc <= '0;
      end else if (we) begin
         case (wr.sel)
            RG_CFG: begin
               mode <= merge(mode, wval, upd);
               if (!wr.masked) lock <= lock | wr.mid[PINS-1:0];
            end
            RG_OE:  oe  <= merge(oe, wval, upd);
            RG_OUT: out <= merge(out, wval, upd);
            RG_IEN: ien <= merge(ien, wval, wmask);
            RG_TRIG: begin
               pol <= merge(pol, wval, wmask);
               if (!wr.masked) begin
                  edg  <= wr.mid[PINS-1:0];
                  anyc <= wr.hi[PINS-1:0];
               end
            end
            default: ;
         endcase
      end
   end

   assign clr = (we && wr.sel == RG_CLR) ? (wval & wmask) : '0;

endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell #(
   parameter int PINS = 8
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [PINS-1:0] cur,
   input  logic [PINS-1:0] prev,
   input  logic [PINS-1:0] pol,
   input  logic [PINS-1:0] edg,
   input  logic [PINS-1:0] anyc,
   input  logic [PINS-1:0] clr,
   output logic [PINS-1:0] status
);

   for (genvar i = 0; i < PINS; i++) begin : g_pin
      logic hit;
      logic st_q;

      always_comb begin
         if (anyc[i])     hit = cur[i] ^ prev[i];
         else if (edg[i]) hit = pol[i] ? (cur[i] & ~prev[i]) : (~cur[i] & prev[i]);
         else             hit = (cur[i] == pol[i]);
      end

      // a new event beats a clear landing in the same cycle
      always_ff @(posedge clk) begin
         if (rst) st_q <= 1'b0;
         else     st_q <= hit | (st_q & ~clr[i]);
      end

      assign status[i] = st_q;
   end

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
   import gpio_bank_pkg::*;
#(
   parameter  int PORT_PINS   = 8,
   parameter  int NUM_PORTS   = 4,
   parameter  int SYNC_STAGES = 2,
   localparam int NUM_PINS    = PORT_PINS * NUM_PORTS,
   localparam int PORT_AW     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
   localparam int ADDR_W      = PORT_AW + REG_SEL_W + 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                bus_en,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic [NUM_PINS-1:0] pin_gpio_mode,
   output logic                irq
);

   // elaboration-time parameter checks
   if (PORT_PINS < 1 || PORT_PINS > LANE_W) begin : g_bad_pins
      $error("PORT_PINS must lie in 1..%0d", LANE_W);
   end
   if (NUM_PORTS < 2 || NUM_PORTS != (1 << PORT_AW)) begin : g_bad_ports
      $error("NUM_PORTS must be a power of two of at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   gpio_wr_t             wr;
   logic [PORT_AW-1:0]   addr_port;
   gpio_reg_e            addr_reg;
   logic [NUM_PORTS-1:0] port_we;

   assign addr_port = bus_addr[PORT_AW-1:0];
   assign addr_reg  = gpio_reg_e'(bus_addr[PORT_AW +: REG_SEL_W]);

   always_comb begin
      wr.en     = bus_en & bus_we;
      wr.masked = bus_addr[ADDR_W-1];
      wr.sel    = addr_reg;
      wr.lo     = bus_wdata[0 +: LANE_W];
      wr.mid    = bus_wdata[LANE_W +: LANE_W];
      wr.hi     = bus_wdata[2*LANE_W +: LANE_W];
   end

   logic unused_wdata;
   assign unused_wdata = ^bus_wdata;

   logic [NUM_PINS-1:0] in_cur, in_prev;

   gpio_in_sync #(
      .W      (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (pin_in),
      .cur  (in_cur),
      .prev (in_prev)
   );

   logic [PORT_PINS-1:0] mode_p [NUM_PORTS];
   logic [PORT_PINS-1:0] lock_p [NUM_PORTS];
   logic [PORT_PINS-1:0] oe_p   [NUM_PORTS];
   logic [PORT_PINS-1:0] out_p  [NUM_PORTS];
   logic [PORT_PINS-1:0] ien_p  [NUM_PORTS];
   logic [PORT_PINS-1:0] pol_p  [NUM_PORTS];
   logic [PORT_PINS-1:0] edg_p  [NUM_PORTS];
   logic [PORT_PINS-1:0] any_p  [NUM_PORTS];
   logic [PORT_PINS-1:0] clr_p  [NUM_PORTS];
   logic [PORT_PINS-1:0] stat_p [NUM_PORTS];
   logic [PORT_PINS-1:0] in_p   [NUM_PORTS];

   logic [NUM_PINS-1:0] mode_all, lock_all, oe_all, out_all;
   logic [NUM_PINS-1:0] ien_all, stat_all, clr_all;

   for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
      assign port_we[g] = wr.en && (addr_port == PORT_AW'(g));

      gpio_port_ctrl #(
         .PINS (PORT_PINS)
      ) u_regs (
         .clk  (clk),
         .rst  (rst),
         .we   (port_we[g]),
         .wr   (wr),
         .mode (mode_p[g]),
         .lock (lock_p[g]),
         .oe   (oe_p[g]),
         .out  (out_p[g]),
         .ien  (ien_p[g]),
         .pol  (pol_p[g]),
         .edg  (edg_p[g]),
         .anyc (any_p[g]),
         .clr  (clr_p[g])
      );

      gpio_irq_cell #(
         .PINS (PORT_PINS)
      ) u_irq (
         .clk    (clk),
         .rst    (rst),
         .cur    (in_cur[g*PORT_PINS +: PORT_PINS]),
         .prev   (in_prev[g*PORT_PINS +: PORT_PINS]),
         .pol    (pol_p[g]),
         .edg    (edg_p[g]),
         .anyc   (any_p[g]),
         .clr    (clr_p[g]),
         .status (stat_p[g])
      );

      assign in_p[g] = in_cur[g*PORT_PINS +: PORT_PINS];
      assign mode_all[g*PORT_PINS +: PORT_PINS] = mode_p[g];
      assign lock_all[g*PORT_PINS +: PORT_PINS] = lock_p[g];
      assign oe_all  [g*PORT_PINS +: PORT_PINS] = oe_p[g];
      assign out_all [g*PORT_PINS +: PORT_PINS] = out_p[g];
      assign ien_all [g*PORT_PINS +: PORT_PINS] = ien_p[g];
      assign stat_all[g*PORT_PINS +: PORT_PINS] = stat_p[g];
      assign clr_all [g*PORT_PINS +: PORT_PINS] = clr_p[g];
   end

   // single-cycle read path
   logic [31:0] rd_word;

   always_comb begin
      rd_word = '0;
      case (addr_reg)
         RG_CFG: begin
            rd_word[0 +: PORT_PINS]      = mode_p[addr_port];
            rd_word[LANE_W +: PORT_PINS] = lock_p[addr_port];
         end
         RG_OE:   rd_word[0 +: PORT_PINS] = oe_p[addr_port];
         RG_OUT:  rd_word[0 +: PORT_PINS] = out_p[addr_port];
         RG_IN:   rd_word[0 +: PORT_PINS] = in_p[addr_port];
         RG_STAT: rd_word[0 +: PORT_PINS] = stat_p[addr_port];
         RG_IEN:  rd_word[0 +: PORT_PINS] = ien_p[addr_port];
         RG_TRIG: begin
            rd_word[0 +: PORT_PINS]        = pol_p[addr_port];
            rd_word[LANE_W +: PORT_PINS]   = edg_p[addr_port];
            rd_word[2*LANE_W +: PORT_PINS] = any_p[addr_port];
         end
         default: rd_word = '0;
      endcase
   end

   assign bus_rdata     = bus_en ? rd_word : '0;
   assign pin_gpio_mode = mode_all;
   assign pin_oe        = oe_all;
   assign pin_out       = out_all;
   assign irq           = |(stat_all & ien_all);

endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
   parameter int NPINS  = 32,
   parameter int NPORTS = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_en,
   input logic              wr_masked,
   input logic              irq,
   input logic [NPINS-1:0]  lock_all,
   input logic [NPINS-1:0]  mode_all,
   input logic [NPINS-1:0]  oe_all,
   input logic [NPINS-1:0]  out_all,
   input logic [NPINS-1:0]  stat_all,
   input logic [NPINS-1:0]  ien_all,
   input logic [NPINS-1:0]  clr_all,
   input logic [NPORTS-1:0] port_we
);

   // R3: lock bits only ever rise
   a_r3_lock_sticky: assert property (@(posedge clk) disable iff (rst)
      (lock_all & $past(lock_all)) == $past(lock_all));

   // R3: locked pins keep mode, enable and value
   a_r3_locked_mode_frozen: assert property (@(posedge clk) disable iff (rst)
      ((mode_all ^ $past(mode_all)) & $past(lock_all)) == '0);

   a_r3_locked_oe_frozen: assert property (@(posedge clk) disable iff (rst)
      ((oe_all ^ $past(oe_all)) & $past(lock_all)) == '0);

   a_r3_locked_out_frozen: assert property (@(posedge clk) disable iff (rst)
      ((out_all ^ $past(out_all)) & $past(lock_all)) == '0);

   // R11: masked writes never touch the lock field
   a_r11_masked_keeps_lock: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_masked) |=> $stable(lock_all));

   // R9: a status bit only falls where a clear was written
   a_r9_fall_needs_clear: assert property (@(posedge clk) disable iff (rst)
      ((~stat_all & $past(stat_all) & ~$past(clr_all)) == '0));

   // R10: no enables, no interrupt
   a_r10_masked_irq_quiet: assert property (@(posedge clk) disable iff (rst)
      (ien_all == '0) |-> !irq);

   // R1: a write reaches at most one port
   a_r1_one_port_written: assert property (@(posedge clk) disable iff (rst)
      $onehot0(port_we));

endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(
   .NPINS  (NUM_PINS),
   .NPORTS (NUM_PORTS)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .wr_en     (wr.en),
   .wr_masked (wr.masked),
   .irq       (irq),
   .lock_all  (lock_all),
   .mode_all  (mode_all),
   .oe_all    (oe_all),
   .out_all   (out_all),
   .stat_all  (stat_all),
   .ien_all   (ien_all),
   .clr_all   (clr_all),
   .port_we   (port_we)
);

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst;
   logic        bus_en, bus_we;
   logic [5:0]  bus_addr;
   logic [31:0] bus_wdata, bus_rdata;
   logic [31:0] pins, pin_out, pin_oe, pin_gpio_mode;
   logic        irq;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;

   gpio_bank_ctrl u_dut (
      .clk           (clk),
      .rst           (rst),
      .bus_en        (bus_en),
      .bus_we        (bus_we),
      .bus_addr      (bus_addr),
      .bus_wdata     (bus_wdata),
      .bus_rdata     (bus_rdata),
      .pin_in        (pins),
      .pin_out       (pin_out),
      .pin_oe        (pin_oe),
      .pin_gpio_mode (pin_gpio_mode),
      .irq           (irq)
   );

   // ---------------- behavioural reference model ----------------
   logic [31:0] m_mode, m_lock, m_oe, m_out, m_ien, m_pol, m_edg, m_any;
   logic [31:0] m_stat, m_s1, m_s2, m_prev, m_ev, m_clr;
   logic [7:0]  m_wm, m_wv, m_upd;
   int          m_p;

   always @(posedge clk) begin
      if (rst) begin
         m_mode = 0; m_lock = 0; m_oe = 0; m_out = 0; m_ien = 0;
         m_pol = 0; m_edg = 0; m_any = 0; m_stat = 0;
         m_s1 = 0; m_s2 = 0; m_prev = 0;
      end else begin
         for (int i = 0; i < 32; i++) begin
            if (m_any[i])      m_ev[i] = m_s2[i] != m_prev[i];
            else if (m_edg[i]) m_ev[i] = m_pol[i] ? (m_s2[i] && !m_prev[i])
                                                  : (!m_s2[i] && m_prev[i]);
            else               m_ev[i] = m_s2[i] == m_pol[i];
         end
         m_clr = 0;
         if (bus_en && bus_we) begin
            m_p   = int'(bus_addr[1:0]);
            m_wm  = bus_addr[5] ? bus_wdata[15:8] : 8'hFF;
            m_wv  = bus_wdata[7:0];
            m_upd = m_wm & ~m_lock[m_p*8 +: 8];
            case (bus_addr[4:2])
               3'd0: begin
                  m_mode[m_p*8 +: 8] = (m_mode[m_p*8 +: 8] & ~m_upd) | (m_wv & m_upd);
                  if (!bus_addr[5]) m_lock[m_p*8 +: 8] = m_lock[m_p*8 +: 8] | bus_wdata[15:8];
               end
               3'd1: m_oe[m_p*8 +: 8]  = (m_oe[m_p*8 +: 8] & ~m_upd) | (m_wv & m_upd);
               3'd2: m_out[m_p*8 +: 8] = (m_out[m_p*8 +: 8] & ~m_upd) | (m_wv & m_upd);
               3'd5: m_ien[m_p*8 +: 8] = (m_ien[m_p*8 +: 8] & ~m_wm) | (m_wv & m_wm);
               3'd6: begin
                  m_pol[m_p*8 +: 8] = (m_pol[m_p*8 +: 8] & ~m_wm) | (m_wv & m_wm);
                  if (!bus_addr[5]) begin
                     m_edg[m_p*8 +: 8] = bus_wdata[15:8];
                     m_any[m_p*8 +: 8] = bus_wdata[23:16];
                  end
               end
               3'd7: m_clr[m_p*8 +: 8] = m_wv & m_wm;
               default: ;
            endcase
         end
         m_stat = m_ev | (m_stat & ~m_clr);
         m_prev = m_s2;
         m_s2   = m_s1;
         m_s1   = pins;
      end
   end

   function automatic logic [31:0] model_read(input logic [5:0] a);
      int p = int'(a[1:0]);
      case (a[4:2])
         3'd0: return {16'h0, m_lock[p*8 +: 8], m_mode[p*8 +: 8]};
         3'd1: return {24'h0, m_oe[p*8 +: 8]};
         3'd2: return {24'h0, m_out[p*8 +: 8]};
         3'd3: return {24'h0, m_s2[p*8 +: 8]};
         3'd4: return {24'h0, m_stat[p*8 +: 8]};
         3'd5: return {24'h0, m_ien[p*8 +: 8]};
         3'd6: return {8'h0, m_any[p*8 +: 8], m_edg[p*8 +: 8], m_pol[p*8 +: 8]};
         default: return 32'h0;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // per-clock comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (!rst) begin
         chk("R2 pin_gpio_mode vs model", pin_gpio_mode, m_mode);
         chk("R4 pin_oe vs model", pin_oe, m_oe);
         chk("R4 pin_out vs model", pin_out, m_out);
         chk("R10 irq vs model", {31'h0, irq}, {31'h0, |(m_stat & m_ien)});
         chk("R1 bus_rdata vs model", bus_rdata,
             bus_en ? model_read(bus_addr) : 32'h0);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(posedge clk); #2;
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
   endtask

   task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
      @(posedge clk); #2;
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a; bus_wdata = 32'h0;
      #5 chk(tag, bus_rdata, exp);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #2;
         bus_en = 1'b0; bus_we = 1'b0;
      end
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      rst = 1'b1; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0;
      bus_wdata = '0; pins = '0;
      repeat (3) @(posedge clk);
      #2 rst = 1'b0;
      #5;
      chk("R12 reset pin_oe", pin_oe, 32'h0);
      chk("R12 reset pin_out", pin_out, 32'h0);
      chk("R12 reset pin_gpio_mode", pin_gpio_mode, 32'h0);
      chk("R12 reset irq", {31'h0, irq}, 32'h0);
      rd(6'h00, 32'h0, "R12 reset config port0");
      idle(2);
      rd(6'h10, 32'h0000_00FF, "R6 level-low default sets status");

      // outputs on port 1
      wr(6'h05, 32'h0000_00A5);
      wr(6'h09, 32'h0000_003C);
      rd(6'h05, 32'h0000_00A5, "R4 oe port1 readback");

      // lock on port 0, low nibble
      wr(6'h00, 32'h0000_0F0F);
      wr(6'h00, 32'h0000_00F0);
      rd(6'h00, 32'h0000_0FFF, "R3 lock kept, unlocked mode bits written");
      wr(6'h00, 32'h0000_0000);
      rd(6'h00, 32'h0000_0F0F, "R3 locked mode bits ignore write");
      wr(6'h04, 32'h0000_00FF);
      rd(6'h04, 32'h0000_00F0, "R3 locked oe bits ignore write");

      // masked alias writes
      wr(6'h06, 32'h0000_000F);
      wr(6'h26, 32'h0000_C080);
      rd(6'h06, 32'h0000_008F, "R11 masked oe merge");
      wr(6'h20, 32'h0000_FFF0);
      rd(6'h20, 32'h0000_0FFF, "R11 masked config keeps lock and locked bits");

      // input sampling on port 1 with outputs enabled
      pins[15:8] = 8'h5A;
      idle(3);
      rd(6'h0D, 32'h0000_005A, "R5 input reflects pins");
      wr(6'h0D, 32'h0000_00FF);
      rd(6'h0D, 32'h0000_005A, "R5 input ignores writes");

      // triggers on port 3: pin24 rising, pin25 any change, 26..31 level high
      wr(6'h1B, 32'h0002_01FD);
      wr(6'h1F, 32'h0000_00FF);
      rd(6'h13, 32'h0, "R9 clear empties status");
      wr(6'h13, 32'h0000_00FF);
      rd(6'h13, 32'h0, "R9 status writes ignored");
      rd(6'h1F, 32'h0, "R9 clear reads zero");
      pins[25:24] = 2'b11;
      idle(4);
      rd(6'h13, 32'h0000_0003, "R7 R8 rising edge sets status");
      wr(6'h1F, 32'h0000_0003);
      rd(6'h13, 32'h0, "R9 clear after edge");
      pins[25:24] = 2'b00;
      idle(4);
      rd(6'h13, 32'h0000_0002, "R8 any-change sees fall, R7 rising-only ignores it");
      pins[26] = 1'b1;
      idle(4);
      rd(6'h13, 32'h0000_0006, "R6 level high sets status");
      wr(6'h1F, 32'h0000_0006);
      rd(6'h13, 32'h0000_0004, "R9 set wins over clear");
      wr(6'h1F, 32'h0000_0000);
      rd(6'h13, 32'h0000_0004, "R9 zero clear has no effect");
      chk("R10 latched but disabled gives no irq", {31'h0, irq}, 32'h0);
      wr(6'h17, 32'h0000_0004);
      rd(6'h17, 32'h0000_0004, "R10 enable readback");
      chk("R10 enabled pending raises irq", {31'h0, irq}, 32'h1);
      pins[26] = 1'b0;
      idle(4);
      wr(6'h1F, 32'h0000_0004);
      idle(1);
      #5 chk("R10 irq drops after clear", {31'h0, irq}, 32'h0);

      // masked trigger write changes polarity only
      wr(6'h3B, 32'h0000_FF00);
      rd(6'h1B, 32'h0002_0100, "R11 masked trigger write");
      idle(3);
      finish_run();
   end

endmodule